// File: doc/BRIEF.md
# Lane-Interleaved Parallel-to-Serial Serializer

This block turns a wide parallel word arriving at a slow rate into a narrow stream of beats at a faster rate. The ratio between the two rates is a whole number, `RATIO = OUT_RATE / IN_RATE`. Each output beat carries `IN_BITS / RATIO` lanes. The word is split in an interleaved way: at beat `i`, lane `j` carries word bit `j*RATIO + i`. A binary tree of 2:1 multiplexers picks each beat. The tree's select bits come from a beat counter that runs in the fast clock domain. Counter bit 0 toggles every beat, and each higher bit toggles at half the rate of the bit below it. The root of the tree is steered by the most significant counter bit.

The block signals, through `word_take`, the cycle in which it samples the next word. In that cycle the upstream logic presents a word with `in_valid`. The sampled word is held for `RATIO` beats and sent out with beat 0 first. When the rates are equal, the block becomes a plain wire from input to output with no storage.

Top module: `ser_tree_serializer`

## Requirements
- R1: `RATIO = OUT_RATE / IN_RATE` must be a whole number, a power of two, and divide `IN_BITS`. Any other setting stops elaboration with an error. The output is `IN_BITS / RATIO` bits wide (4 bits for the default 16-bit word at a 4:1 rate).
- R2: While `rst_n` is low at a clock edge, the block synchronously clears the beat counter, the held word and `out_valid`. `out_lanes` is all zeros until the first word is captured, and whenever `out_valid` is low.
- R3: The beat counter starts at 0 after reset and steps by one each clock, wrapping from `RATIO-1` to 0. `word_take` is high exactly in the cycles where the counter is at `RATIO-1`.
- R4: At the clock edge that ends a cycle with `word_take` high, the held word is loaded with `in_word` if `in_valid` is high, or with zeros if it is low. `in_word` and `in_valid` have no effect in any other cycle.
- R5: In the cycle where the counter holds value `i`, lane `j` of `out_lanes` equals bit `j*RATIO + i` of the held word. A captured word therefore appears in full over the next `RATIO` beats, starting with beat 0.
- R6: `out_valid` is high during the `RATIO` beats that follow a capture with `in_valid` high, and low during the beats that follow a capture without it. It first rises in the cycle right after the first valid load.
- R7: When `RATIO` is 1, `out_lanes` follows `in_word` and `out_valid` follows `in_valid` combinationally, and `word_take` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-beat clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_word | input | IN_BITS | Parallel word to serialize |
| in_valid | input | 1 | Marks `in_word` as a real word in a `word_take` cycle |
| word_take | output | 1 | High in the last beat; the word presented now is captured |
| out_lanes | output | IN_BITS/RATIO | Serial lanes of the current beat |
| out_valid | output | 1 | Current beat belongs to a valid word |

## Verification
The bench sends walking-one words first. A tree that reversed its select order, or a reindexing that used `i*OUT_BITS + j` instead of the interleaved mapping, would send a single set bit out on the wrong lane or in the wrong beat. `in_word` is changed with random values in every non-capture cycle. A design that sampled the word outside the `word_take` cycle, or that passed the input straight through, would then show the wrong data. Some capture cycles have `in_valid` low, so a design that kept the previous word or kept `out_valid` high would be caught. A reset in the middle of a word checks that beat 0 comes first again afterwards. A second instance with equal rates checks that the bypass has no delay.

// File: rtl/ser_tree_pkg.sv
`timescale 1ns/1ps
// Package: ser_tree_pkg
// Shared helpers for the lane-interleaved serializer.
// Assumes: all arguments are elaboration-time constants.
package ser_tree_pkg;

    // Returns 1 when v is a nonzero power of two.
    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    // Width of the beat counter; at least one bit so vectors stay legal.
    function automatic int sel_width(input int ratio);
        return (ratio > 1) ? $clog2(ratio) : 1;
    endfunction

endpackage

// File: rtl/ser_beat_counter.sv
`timescale 1ns/1ps
// Module: ser_beat_counter
// Counts output beats from 0 to RATIO-1 and wraps. Bit k of the count toggles
// every 2**k beats. It therefore gives the select of tree level k, where bit 0
// is the fastest select and the top bit steers the root.
// Assumes: RATIO is a power of two of at least 2.
module ser_beat_counter #(
    parameter int RATIO = 4,
    localparam int SEL_W = ser_tree_pkg::sel_width(RATIO)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SEL_W-1:0] beat_o,
    output logic             last_o
);
    localparam logic [SEL_W-1:0] LAST_BEAT = SEL_W'(RATIO - 1);

    // Advance the beat count, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_o <= '0;
        end else begin
            beat_o <= beat_o + 1'b1;
        end
    end

    // Flag the final beat of a word.
    always_comb begin
        last_o = (beat_o == LAST_BEAT);
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !last_o |=> beat_o == SEL_W'($past(beat_o) + 1'b1)); // R3
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> beat_o == '0); // R3
    AST_FAST_SEL_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> beat_o[0] != $past(beat_o[0])); // R3

endmodule

// File: rtl/ser_lane_reindex.sv
`timescale 1ns/1ps
// Module: ser_lane_reindex
// Pure wiring. Regroups the held word so that multiplexer input i carries, in
// lane j, word bit j*RATIO+i. Input i fills bits [i*OUT_BITS +: OUT_BITS].
// Assumes: IN_BITS is a multiple of RATIO.
module ser_lane_reindex #(
    parameter int IN_BITS = 16,
    parameter int RATIO   = 4,
    localparam int OUT_BITS = IN_BITS / RATIO
) (
    input  logic [IN_BITS-1:0] word_i,
    output logic [IN_BITS-1:0] grouped_o
);
    for (genvar i = 0; i < RATIO; i++) begin : g_beat
        for (genvar j = 0; j < OUT_BITS; j++) begin : g_lane
            assign grouped_o[i*OUT_BITS + j] = word_i[j*RATIO + i];
        end
    end

endmodule

// File: rtl/ser_mux_tree.sv
`timescale 1ns/1ps
// Module: ser_mux_tree
// RATIO-to-1 tree of 2:1 multiplexers, each OUT_BITS wide. Level 1 pairs
// neighbouring inputs under sel_i[0]. Level l pairs the results of level l-1
// under sel_i[l-1]. The root uses the top select bit. Output = input[sel_i].
// Assumes: RATIO is a power of two of at least 2.
module ser_mux_tree #(
    parameter int RATIO    = 4,
    parameter int OUT_BITS = 4,
    localparam int SEL_W   = ser_tree_pkg::sel_width(RATIO)
) (
    input  logic [RATIO*OUT_BITS-1:0] inputs_i,
    input  logic [SEL_W-1:0]          sel_i,
    output logic [OUT_BITS-1:0]       out_o
);
    for (genvar l = 0; l <= SEL_W; l++) begin : g_lvl
        localparam int NODES = RATIO >> l;
        logic [OUT_BITS-1:0] node [NODES];
        if (l == 0) begin : g_leaf
            for (genvar m = 0; m < NODES; m++) begin : g_in
                assign node[m] = inputs_i[m*OUT_BITS +: OUT_BITS];
            end
        end else begin : g_mux
            for (genvar m = 0; m < NODES; m++) begin : g_pair
                assign node[m] = sel_i[l-1] ? g_lvl[l-1].node[2*m+1]
                                            : g_lvl[l-1].node[2*m];
            end
        end
    end

    assign out_o = g_lvl[SEL_W].node[0];

endmodule

// File: rtl/ser_tree_serializer.sv
`timescale 1ns/1ps
// Module: ser_tree_serializer
// Parallel-to-serial converter with interleaved lanes. It captures one word
// per RATIO beats, in the last beat (word_take), and sends beat i in the cycle
// where the beat count is i. When RATIO is 1 it is a plain wire.
// Assumes: one clock at the output-beat rate, synchronous active-low reset,
// and upstream logic that presents a word when word_take is high.
module ser_tree_serializer #(
    parameter int IN_RATE  = 250,
    parameter int OUT_RATE = 1000,
    parameter int IN_BITS  = 16,
    localparam int RATIO    = (IN_RATE > 0) ? (OUT_RATE / IN_RATE) : 1,
    localparam int OUT_BITS = (RATIO > 0) ? (IN_BITS / RATIO) : IN_BITS,
    localparam int SEL_W    = ser_tree_pkg::sel_width(RATIO)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IN_BITS-1:0]  in_word,
    input  logic                in_valid,
    output logic                word_take,
    output logic [OUT_BITS-1:0] out_lanes,
    output logic                out_valid
);
    // Elaboration checks on the rate and width settings (R1).
    if (IN_RATE <= 0 || OUT_RATE < IN_RATE) begin : g_bad_rates
        $error("serializer: output rate must be at least the input rate");
    end
    if (IN_RATE > 0 && (OUT_RATE % IN_RATE) != 0) begin : g_bad_ratio
        $error("serializer: rate ratio is not a whole number");
    end
    if (!ser_tree_pkg::is_pow2(RATIO)) begin : g_bad_pow2
        $error("serializer: rate ratio must be a power of two");
    end
    if (RATIO > 0 && (IN_BITS % RATIO) != 0) begin : g_bad_width
        $error("serializer: word width must be a multiple of the ratio");
    end

    if (RATIO == 1) begin : g_bypass
        // Equal rates: straight wires, no storage.
        assign out_lanes = in_word;
        assign out_valid = in_valid;
        assign word_take = 1'b1;
    end else begin : g_tree
        logic [SEL_W-1:0]   beat;
        logic               last_beat;
        logic [IN_BITS-1:0] hold_q;
        logic               hold_vld_q;
        logic [IN_BITS-1:0] grouped;

        ser_beat_counter #(.RATIO(RATIO)) u_count (
            .clk    (clk),
            .rst_n  (rst_n),
            .beat_o (beat),
            .last_o (last_beat)
        );

        // Load the next word (or zeros) at the end of the last beat.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q     <= '0;
                hold_vld_q <= 1'b0;
            end else if (last_beat) begin
                hold_q     <= in_valid ? in_word : '0;
                hold_vld_q <= in_valid;
            end
        end

        ser_lane_reindex #(.IN_BITS(IN_BITS), .RATIO(RATIO)) u_reindex (
            .word_i    (hold_q),
            .grouped_o (grouped)
        );

        ser_mux_tree #(.RATIO(RATIO), .OUT_BITS(OUT_BITS)) u_tree (
            .inputs_i (grouped),
            .sel_i    (beat),
            .out_o    (out_lanes)
        );

        assign out_valid = hold_vld_q;
        assign word_take = last_beat;

        AST_RESET_CLEARS: assert property (@(posedge clk)
            !rst_n |=> (!out_valid && out_lanes == '0)); // R2
        AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid |-> out_lanes == '0); // R2
        AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            !word_take |=> $stable(hold_q)); // R4
        AST_VALID_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (word_take && in_valid) |=> out_valid); // R6
        AST_EMPTY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (word_take && !in_valid) |=> !out_valid); // R6
        AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !word_take |=> $stable(out_valid)); // R6
    end

endmodule

// File: tb/ser_tree_serializer_bench.sv
`timescale 1ns/1ps
// Bench for ser_tree_serializer: a 4:1 instance with a 16-bit word and a 1:1
// bypass instance with a 4-bit word. Expected values are computed from the
// interleave rule j*RATIO+i.
module ser_tree_serializer_bench;
    localparam int R     = 4;
    localparam int WB    = 16;
    localparam int LANES = WB / R;

    logic clk = 1'b0;
    logic rst_n;
    logic [WB-1:0]    in_word;
    logic             in_valid;
    logic             word_take;
    logic [LANES-1:0] out_lanes;
    logic             out_valid;

    logic [3:0] b_word;
    logic       b_valid;
    logic       b_take;
    logic [3:0] b_lanes;
    logic       b_out_valid;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    ser_tree_serializer #(.IN_RATE(250), .OUT_RATE(1000), .IN_BITS(WB)) u_ser_tree_serializer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_word   (in_word),
        .in_valid  (in_valid),
        .word_take (word_take),
        .out_lanes (out_lanes),
        .out_valid (out_valid)
    );

    ser_tree_serializer #(.IN_RATE(500), .OUT_RATE(500), .IN_BITS(4)) u_ser_tree_serializer_r1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_word   (b_word),
        .in_valid  (b_valid),
        .word_take (b_take),
        .out_lanes (b_lanes),
        .out_valid (b_out_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int exp_cnt;
        logic [WB-1:0] exp_word;
        logic exp_vld;
        logic [WB-1:0] rebuilt;
        logic [LANES-1:0] exp_out;

        rst_n = 1'b0; in_word = '0; in_valid = 1'b0; b_word = '0; b_valid = 1'b0;
        rebuilt = '0;
        // R1: derived output widths
        chk("R1 lane width", $bits(out_lanes), 4);
        chk("R1 bypass width", $bits(b_lanes), 4);
        repeat (3) @(negedge clk);
        chk("R2 reset out", {27'd0, out_valid, out_lanes}, 0);
        rst_n = 1'b1;
        exp_cnt = 0; exp_word = '0; exp_vld = 1'b0;

        for (int c = 0; c < 800; c++) begin
            // Check the state left by the last edge.
            for (int j = 0; j < LANES; j++) exp_out[j] = exp_word[j*R + exp_cnt];
            chk("R5 lanes", 32'(out_lanes), 32'(exp_out));
            chk("R6 valid", 32'(out_valid), 32'(exp_vld));
            chk("R3 take", 32'(word_take), 32'(exp_cnt == R - 1));
            if (!exp_vld) chk("R2 idle zero", 32'(out_lanes), 0);
            for (int j = 0; j < LANES; j++) rebuilt[j*R + exp_cnt] = out_lanes[j];
            if (exp_cnt == R - 1 && exp_vld) chk("R4 rebuilt word", 32'(rebuilt), 32'(exp_word));

            // Drive the next inputs; non-capture cycles get random noise.
            rst_n    = (c != 300 && c != 301 && c != 555);
            in_word  = WB'($urandom);
            in_valid = 1'($urandom);
            if (exp_cnt == R - 1) begin
                if (c < 128) begin
                    in_word  = WB'(1) << ((c / R) % WB);
                    in_valid = 1'b1;
                end else if (c < 200) begin
                    case ((c / R) % 3)
                        0: in_word = 16'hAAAA;
                        1: in_word = 16'h5555;
                        default: in_word = 16'hFFFF;
                    endcase
                    in_valid = 1'b1;
                end else begin
                    in_valid = (($urandom % 4) != 0);
                end
            end
            b_word  = 4'($urandom);
            b_valid = 1'($urandom);
            #1;
            // R7: bypass follows its inputs with no clock
            chk("R7 bypass data", 32'(b_lanes), 32'(b_word));
            chk("R7 bypass valid", 32'(b_out_valid), 32'(b_valid));
            chk("R7 bypass take", 32'(b_take), 1);

            // Model the next edge from the requirements.
            if (!rst_n) begin
                exp_cnt = 0; exp_word = '0; exp_vld = 1'b0;
            end else begin
                if (exp_cnt == R - 1) begin
                    exp_word = in_valid ? in_word : '0;
                    exp_vld  = in_valid;
                end
                exp_cnt = (exp_cnt + 1) % R;
            end
            @(negedge clk);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule